// File: doc/BRIEF.md
# Directional Overcurrent Stage Decision Logic

This block makes the pickup and trip decision for one overcurrent stage of a three-phase protection relay. Its per-phase inputs are already computed: two magnitude comparisons (normal threshold and cold-load threshold) and a forward-direction flag. It also takes status inputs for cold-load pickup, second-harmonic restraint, voltage-transformer supervision fault, undervoltage start and external block. The outputs are a start, a definite-time trip, and inhibit lines to lower-set stages.

All state advances only on cycles where `tick` is high, so the operate and reset times are counted in ticks. Settings choose the following:
- directional or magnitude-only operation;
- 1-of-3 or 2-of-3 phase voting;
- the cold-load behaviour;
- the reaction to a supervision fault;
- optional restraint and undervoltage gating;
- which lower stages are inhibited.

Top module: `dir_oc_stage`

## Requirements
- R1: A synchronous active-high `rst` clears `start`, `trip` and `inhibit` and empties both timers.
- R2: With `cfg_dir`=1 a phase qualifies only if its magnitude flag and its `fwd` bit are both high. With `cfg_dir`=0 the magnitude flag alone qualifies the phase.
- R3: With `cfg_vote2`=0 one qualifying phase is enough. With `cfg_vote2`=1 at least two phases must qualify.
- R4: `cfg_clp` selects the cold-load behaviour. Value 1 means that while `clp_act` is high, the phases are judged on `mag_alt` instead of `mag_hi`. Value 2 means that while `clp_act` is high, the stage cannot pick up. Values 0 and 3 ignore `clp_act`.
- R5: While `vt_fault` is high, the stage cannot pick up if `cfg_vt_fb`=0. If `cfg_vt_fb`=1, the stage runs magnitude-only.
- R6: When `cfg_h2_en`=1 and `h2_rest` is high, the stage cannot pick up.
- R7: When `cfg_uv_and`=1, a pickup also needs `uv_start` high on the same tick.
- R8: `start` rises on the first tick after a qualifying tick. `trip` rises `t_op` ticks later, provided the internal pickup is held throughout. With `t_op`=0, `trip` rises together with `start`.
- R9: After qualifying conditions stop, the internal pickup is held for `t_rst` further ticks and then released on the next non-qualifying tick. During the hold the operate timer keeps counting, and on release both timers and `trip` clear.
- R10: `inhibit[k]` equals `start` when `cfg_inh[k]`=1 and is 0 otherwise.
- R11: `ext_blk` forces `start`, `trip` and `inhibit` low in the same cycle and prevents new pickup.
- R12: A tick on which any setting differs from its value on the previous tick restarts the operate timer and clears `trip`. `cfg_inh` is not counted as a setting for this purpose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample enable |
| mag_hi | input | 3 | Per-phase flag: above normal threshold |
| mag_alt | input | 3 | Per-phase flag: above cold-load threshold |
| fwd | input | 3 | Per-phase flag: forward direction |
| clp_act | input | 1 | Cold-load pickup active |
| h2_rest | input | 1 | Second-harmonic restraint asserted |
| vt_fault | input | 1 | Voltage supervision fault |
| uv_start | input | 1 | Undervoltage start |
| ext_blk | input | 1 | External block |
| cfg_dir | input | 1 | 1 = directional |
| cfg_vote2 | input | 1 | 1 = 2-of-3 voting |
| cfg_clp | input | 2 | Cold-load mode (0/3 off, 1 alternate threshold, 2 block) |
| cfg_vt_fb | input | 1 | 1 = fall back to magnitude-only on supervision fault |
| cfg_h2_en | input | 1 | Enable harmonic restraint |
| cfg_uv_and | input | 1 | Require undervoltage start |
| cfg_inh | input | NLOW | Per-lower-stage inhibit enable |
| t_op | input | TW | Operate time in ticks |
| t_rst | input | TW | Reset hold time in ticks |
| start | output | 1 | Stage started |
| trip | output | 1 | Stage tripped |
| inhibit | output | NLOW | Inhibit to lower stages |

## Verification
The bench builds the block with TW=8 and NLOW=4. The 8-bit timer width makes the largest operate setting (255 ticks) short enough to run to completion, so the saturation edge of the counter comparison is exercised. The extra inhibit line over the default lets the bench drive a non-trivial mask pattern across four lower stages. One phase of the run drops `tick` on alternate cycles, which shows that the timers count ticks and not clocks.

// File: rtl/dir_oc_stage.sv
module dir_oc_stage #(
  parameter int TW   = 16,
  parameter int NLOW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [2:0]      mag_hi,
  input  logic [2:0]      mag_alt,
  input  logic [2:0]      fwd,
  input  logic            clp_act,
  input  logic            h2_rest,
  input  logic            vt_fault,
  input  logic            uv_start,
  input  logic            ext_blk,
  input  logic            cfg_dir,
  input  logic            cfg_vote2,
  input  logic [1:0]      cfg_clp,
  input  logic            cfg_vt_fb,
  input  logic            cfg_h2_en,
  input  logic            cfg_uv_and,
  input  logic [NLOW-1:0] cfg_inh,
  input  logic [TW-1:0]   t_op,
  input  logic [TW-1:0]   t_rst,
  output logic            start,
  output logic            trip,
  output logic [NLOW-1:0] inhibit
);
  localparam int CW = 7 + 2 * TW;

  logic [TW-1:0] op_cnt, rs_cnt;
  logic          held, trip_q;
  logic [CW-1:0] cfg_q;
  logic [2:0]    thr, ph;
  logic          dir_eff, voted, blocked, pick, held_n, cfg_chg;
  logic [CW-1:0] cfg_now;

  assign cfg_now = {cfg_dir, cfg_vote2, cfg_clp, cfg_vt_fb, cfg_h2_en, cfg_uv_and, t_op, t_rst};
  assign cfg_chg = cfg_now != cfg_q;

  assign thr     = (cfg_clp == 2'd1 && clp_act) ? mag_alt : mag_hi;
  assign dir_eff = cfg_dir && !(vt_fault && cfg_vt_fb);
  assign ph      = dir_eff ? (thr & fwd) : thr;
  assign voted   = cfg_vote2 ? ((ph[0] & ph[1]) | (ph[0] & ph[2]) | (ph[1] & ph[2])) : |ph;

  assign blocked = ext_blk
                 | (cfg_clp == 2'd2 && clp_act)
                 | (vt_fault && !cfg_vt_fb)
                 | (cfg_h2_en && h2_rest);
  assign pick    = voted && !blocked && (!cfg_uv_and || uv_start);
  assign held_n  = pick || (held && rs_cnt < t_rst);

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= 1'b0;
      trip_q <= 1'b0;
      op_cnt <= '0;
      rs_cnt <= '0;
      cfg_q  <= cfg_now;
    end else if (tick) begin
      cfg_q <= cfg_now;
      held  <= held_n;
      if (pick || !held_n) rs_cnt <= '0;
      else                 rs_cnt <= rs_cnt + 1'b1;
      if (!held_n || cfg_chg) begin
        op_cnt <= '0;
        trip_q <= 1'b0;
      end else if (op_cnt >= t_op) begin
        trip_q <= 1'b1;
      end else begin
        op_cnt <= op_cnt + 1'b1;
      end
    end
  end

  assign start   = held && !ext_blk;
  assign trip    = trip_q && !ext_blk;
  assign inhibit = cfg_inh & {NLOW{start}};
endmodule

module dir_oc_stage_chk #(
  parameter int TW   = 16,
  parameter int NLOW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            tick,
  input logic            ext_blk,
  input logic            h2_rest,
  input logic            cfg_h2_en,
  input logic [TW-1:0]   t_op,
  input logic            start,
  input logic            trip,
  input logic [NLOW-1:0] inhibit
);
  a_r1_reset_clear: assert property (@(posedge clk) $past(rst) |-> (!start && !trip && inhibit == '0));
  a_r11_ext_block: assert property (@(posedge clk) disable iff (rst) ext_blk |-> (!start && !trip));
  a_r8_trip_with_start: assert property (@(posedge clk) disable iff (rst) trip |-> start);
  a_r8_rise_after_start: assert property (@(posedge clk) disable iff (rst)
    ($rose(trip) && $past(!ext_blk) && t_op != '0) |-> $past(start));
  a_r10_inhibit_needs_start: assert property (@(posedge clk) disable iff (rst) (inhibit != '0) |-> start);
  a_r9_change_on_tick: assert property (@(posedge clk) disable iff (rst)
    ($rose(start) && !$past(ext_blk) && !$past(rst)) |-> $past(tick));
  a_r6_restraint: assert property (@(posedge clk) disable iff (rst)
    ($past(tick) && $past(cfg_h2_en && h2_rest) && !$past(start) && !$past(rst)) |-> !start);
endmodule

bind dir_oc_stage dir_oc_stage_chk #(.TW(TW), .NLOW(NLOW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .ext_blk(ext_blk), .h2_rest(h2_rest),
  .cfg_h2_en(cfg_h2_en), .t_op(t_op), .start(start), .trip(trip), .inhibit(inhibit)
);

// File: tb/dir_oc_stage_bench.sv
module dir_oc_stage_bench;
  localparam int TW = 8;
  localparam int NLOW = 4;

  logic clk = 0, rst = 1, tick = 1;
  logic [2:0] mag_hi = 0, mag_alt = 0, fwd = 0;
  logic clp_act = 0, h2_rest = 0, vt_fault = 0, uv_start = 0, ext_blk = 0;
  logic cfg_dir = 0, cfg_vote2 = 0, cfg_vt_fb = 0, cfg_h2_en = 0, cfg_uv_and = 0;
  logic [1:0] cfg_clp = 0;
  logic [NLOW-1:0] cfg_inh = 4'b1011;
  logic [TW-1:0] t_op = 3, t_rst = 0;
  logic start, trip;
  logic [NLOW-1:0] inhibit;

  int checks = 0, fails = 0;
  string req = "R1";
  bit alt_tick = 0;

  always #2 clk = ~clk;

  dir_oc_stage #(.TW(TW), .NLOW(NLOW)) u_dir_oc_stage (.*);

  int m_held, m_trip, m_op, m_rs;
  logic [6+2*TW:0] m_cfg;

  function automatic logic [6+2*TW:0] cfg_vec();
    return {cfg_dir, cfg_vote2, cfg_clp, cfg_vt_fb, cfg_h2_en, cfg_uv_and, t_op, t_rst};
  endfunction

  function automatic bit qualifies();
    int n = 0;
    bit dirmode;
    dirmode = cfg_dir && !(vt_fault && cfg_vt_fb);
    for (int p = 0; p < 3; p++) begin
      bit m = (cfg_clp == 1 && clp_act) ? mag_alt[p] : mag_hi[p];
      if (m && (!dirmode || fwd[p])) n++;
    end
    if (cfg_vote2 ? n < 2 : n < 1) return 0;
    if (ext_blk) return 0;
    if (cfg_clp == 2 && clp_act) return 0;
    if (vt_fault && !cfg_vt_fb) return 0;
    if (cfg_h2_en && h2_rest) return 0;
    if (cfg_uv_and && !uv_start) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_held = 0; m_trip = 0; m_op = 0; m_rs = 0; m_cfg = cfg_vec();
    end else if (tick) begin
      bit q, keep, chg;
      q = qualifies();
      chg = (cfg_vec() != m_cfg);
      m_cfg = cfg_vec();
      if (q) begin keep = 1; m_rs = 0; end
      else if (m_held && m_rs < int'(t_rst)) begin keep = 1; m_rs++; end
      else begin keep = 0; m_rs = 0; end
      m_held = keep;
      if (!keep || chg) begin m_op = 0; m_trip = 0; end
      else if (m_op >= int'(t_op)) m_trip = 1;
      else m_op++;
    end
  end

  task automatic check();
    logic es, et;
    logic [NLOW-1:0] ei;
    es = m_held && !ext_blk;
    et = m_trip && !ext_blk;
    ei = es ? cfg_inh : '0;
    checks++;
    if (start !== es || trip !== et || inhibit !== ei) begin
      fails++;
      $display("FAIL %s: start/trip/inhibit = %b/%b/%b expected %b/%b/%b at %0t",
               req, start, trip, inhibit, es, et, ei, $time);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check();
      if (alt_tick) tick = ~tick;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    req = "R1"; run(3);
    rst = 0; run(2);
    req = "R8"; mag_hi = 3'b001; run(8);
    mag_hi = 0; run(3);
    t_op = 0; run(1); mag_hi = 3'b100; run(4); mag_hi = 0; run(2);
    t_op = 8'hFF; run(1); mag_hi = 3'b010; run(262); mag_hi = 0; t_op = 3; run(3);
    req = "R2"; cfg_dir = 1; run(1); mag_hi = 3'b001; fwd = 3'b000; run(4);
    fwd = 3'b001; run(6); cfg_dir = 0; fwd = 0; run(3); mag_hi = 0; run(3);
    req = "R3"; cfg_vote2 = 1; run(1); mag_hi = 3'b001; run(4); mag_hi = 3'b101; run(6);
    mag_hi = 0; cfg_vote2 = 0; run(3);
    req = "R4"; cfg_clp = 1; clp_act = 1; mag_alt = 3'b010; run(6);
    clp_act = 0; run(3); mag_hi = 3'b001; cfg_clp = 2; clp_act = 1; run(4);
    clp_act = 0; run(4); cfg_clp = 3; clp_act = 1; run(4);
    mag_hi = 0; mag_alt = 0; clp_act = 0; cfg_clp = 0; run(3);
    req = "R5"; cfg_dir = 1; mag_hi = 3'b011; fwd = 0; vt_fault = 1; run(4);
    cfg_vt_fb = 1; run(6); cfg_vt_fb = 0; run(3); vt_fault = 0; cfg_dir = 0; mag_hi = 0; fwd = 0; run(3);
    req = "R6"; mag_hi = 3'b100; h2_rest = 1; run(3); cfg_h2_en = 1; run(4);
    h2_rest = 0; run(5); h2_rest = 1; run(3); h2_rest = 0; cfg_h2_en = 0; mag_hi = 0; run(3);
    req = "R7"; cfg_uv_and = 1; mag_hi = 3'b001; run(4); uv_start = 1; run(6);
    uv_start = 0; run(3); cfg_uv_and = 0; mag_hi = 0; run(3);
    req = "R9"; t_rst = 4; t_op = 6; run(2);
    for (int k = 0; k < 4; k++) begin mag_hi = 3'b010; run(2); mag_hi = 0; run(3); end
    run(8);
    alt_tick = 1;
    for (int k = 0; k < 3; k++) begin mag_hi = 3'b001; run(4); mag_hi = 0; run(7); end
    alt_tick = 0; tick = 1; run(12); t_rst = 0; t_op = 3;
    req = "R10"; cfg_inh = 4'b0110; mag_hi = 3'b111; run(5); cfg_inh = 4'b1001; run(3);
    cfg_inh = 0; run(2); cfg_inh = 4'b1111; run(2);
    req = "R11"; ext_blk = 1; run(3); ext_blk = 0; run(6); mag_hi = 0; run(3);
    req = "R12"; mag_hi = 3'b001; run(3); cfg_vote2 = 1; mag_hi = 3'b011; run(2);
    run(5); t_rst = 1; run(6); cfg_inh = 4'b0001; run(3); mag_hi = 0; run(4);
    req = "R1"; mag_hi = 3'b001; run(5); rst = 1; run(2); rst = 0; run(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule